// File: doc/BRIEF.md
# Registered Signal Routing Port

This block is a multi-bit routing port. Each output bit takes its value from one of several internal candidate signals, chosen by a per-bit select field. A per-bit mask decides how that value reaches the output. With the mask bit set, the value passes through a data flip-flop. With the mask bit clear, the selected signal drives the output directly and is not stored.

While the port's hardware clocking is off, software loads the data register on the instruction-rate tick. This lets it set the output state before hardware clocking starts. While hardware clocking is on, software writes to the data register are locked out. The register then captures the selected inputs each time the chosen clock strobe fires. All clock sources are single-cycle enable strobes that are synchronous to one system clock.

The routed bus is exported in parallel for other blocks to use. A read register samples the routed bus one system clock later.

Top module: `sig_route_port`

## Requirements
- R1: An output bit whose mask bit is 1 shows the data register bit.
- R2: An output bit whose mask bit is 0 follows its selected input combinationally, in the same cycle, with no storage.
- R3: Bit b selects candidate `src_i[b*NSRC + s]`, where s is the value of the field `src_sel_i[b*SEL_W +: SEL_W]`.
- R4: While hardware clocking is off, a write to address 0 loads `wr_data_i` into the data register on an edge where `tick_i` is 1. A write on an edge without `tick_i` is ignored.
- R5: While hardware clocking is on, the data register loads the selected inputs on an edge where the strobe picked by the clock-select field is 1. The other strobes have no effect.
- R6: While hardware clocking is on, writes to address 0 do not change the data register.
- R7: `rd_data_o` equals the value that `route_o` had one system clock earlier. A read in the cycle right after a write therefore returns the earlier value.
- R8: A value preset by software while hardware clocking is off stays on the masked outputs after clocking is enabled, until the first selected strobe.
- R9: Reset clears the data register, the mask, the enable, the clock select and the read register.
- R10: Register addresses are as follows:
  - 0 is the data register.
  - 1 is the mask.
  - 2 is the control register: bit 0 is the enable, and bits [CSEL_W:1] are the clock select.
  - 3 is ignored.

  Writes to the mask and to the control register take effect on the edge of the write, whether or not `tick_i` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Instruction-rate strobe |
| clk_stb_i | input | NCLK | Candidate hardware clock strobes |
| src_i | input | WIDTH*NSRC | Candidate inputs, NSRC per bit |
| src_sel_i | input | WIDTH*SEL_W | Per-bit input select fields |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | WIDTH | Register write data |
| rd_data_o | output | WIDTH | Read register |
| route_o | output | WIDTH | Routed output bus |

## Verification
Several internal faults show on `route_o` in the cycle after the edge where they occur, but only for masked bits. These are a corrupted data register, a missed or spurious strobe capture, and a software write that gets through the lockout. A bypassed bit hides any fault in the data register until its mask bit is set. A wrong mask or a wrong input select shows at once on `route_o`. A fault in the read register shows on `rd_data_o` one cycle after the routed bus it should mirror.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_MASK = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/rsp_src_mux.sv
module rsp_src_mux #(
  parameter int WIDTH = 8,
  parameter int NSRC  = 4,
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [WIDTH*NSRC-1:0]  src_i,
  input  logic [WIDTH*SEL_W-1:0] sel_i,
  output logic [WIDTH-1:0]       vec_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [NSRC-1:0]  cand;
    logic [SEL_W-1:0] fld;
    assign cand = src_i[b*NSRC +: NSRC];
    assign fld  = sel_i[b*SEL_W +: SEL_W];
    assign vec_o[b] = (int'(fld) < NSRC) ? cand[fld] : 1'b0;
  end
endmodule

// File: rtl/rsp_clk_pick.sv
module rsp_clk_pick #(
  parameter int NCLK = 4,
  localparam int CSEL_W = (NCLK > 1) ? $clog2(NCLK) : 1
) (
  input  logic [NCLK-1:0]   stb_i,
  input  logic [CSEL_W-1:0] csel_i,
  output logic              hw_tick_o
);
  assign hw_tick_o = (int'(csel_i) < NCLK) ? stb_i[csel_i] : 1'b0;
endmodule

// File: rtl/rsp_cfg_regs.sv
module rsp_cfg_regs import rsp_pkg::*; #(
  parameter int WIDTH = 8,
  parameter int NCLK  = 4,
  localparam int CSEL_W = (NCLK > 1) ? $clog2(NCLK) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [WIDTH-1:0]  wr_data_i,
  output logic [WIDTH-1:0]  mask_o,
  output logic              en_o,
  output logic [CSEL_W-1:0] csel_o
);
  reg_addr_e addr;
  assign addr = reg_addr_e'(wr_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      en_o   <= 1'b0;
      csel_o <= '0;
    end else if (wr_en_i) begin
      if (addr == ADDR_MASK) mask_o <= wr_data_i;
      if (addr == ADDR_CTRL) begin
        en_o   <= wr_data_i[0];
        csel_o <= wr_data_i[CSEL_W:1];
      end
    end
  end
endmodule

// File: rtl/rsp_data_reg.sv
module rsp_data_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             hw_tick_i,
  input  logic             sw_tick_i,
  input  logic             sw_wr_i,
  input  logic [WIDTH-1:0] sw_data_i,
  input  logic [WIDTH-1:0] hw_data_i,
  output logic [WIDTH-1:0] data_o
);
  logic             load;
  logic [WIDTH-1:0] next;

  // source and clock both swap with the enable
  always_comb begin
    if (en_i) begin
      load = hw_tick_i;
      next = hw_data_i;
    end else begin
      load = sw_tick_i && sw_wr_i;
      next = sw_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_o <= '0;
    else if (load) data_o <= next;
  end
endmodule

// File: rtl/sig_route_port.sv
module sig_route_port import rsp_pkg::*; #(
  parameter int WIDTH = 8,
  parameter int NSRC  = 4,
  parameter int NCLK  = 4,
  localparam int SEL_W  = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int CSEL_W = (NCLK > 1) ? $clog2(NCLK) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic [NCLK-1:0]        clk_stb_i,
  input  logic [WIDTH*NSRC-1:0]  src_i,
  input  logic [WIDTH*SEL_W-1:0] src_sel_i,
  input  logic                   wr_en_i,
  input  logic [1:0]             wr_addr_i,
  input  logic [WIDTH-1:0]       wr_data_i,
  output logic [WIDTH-1:0]       rd_data_o,
  output logic [WIDTH-1:0]       route_o
);
  logic [WIDTH-1:0]  sel_vec;
  logic [WIDTH-1:0]  mask_q;
  logic [WIDTH-1:0]  data_q;
  logic              en_q;
  logic [CSEL_W-1:0] csel_q;
  logic              hw_tick;
  logic              data_wr;

  assign data_wr = wr_en_i && (reg_addr_e'(wr_addr_i) == ADDR_DATA);

  rsp_src_mux #(.WIDTH(WIDTH), .NSRC(NSRC)) u_mux (
    .src_i (src_i),
    .sel_i (src_sel_i),
    .vec_o (sel_vec)
  );

  rsp_clk_pick #(.NCLK(NCLK)) u_clk (
    .stb_i     (clk_stb_i),
    .csel_i    (csel_q),
    .hw_tick_o (hw_tick)
  );

  rsp_cfg_regs #(.WIDTH(WIDTH), .NCLK(NCLK)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .mask_o    (mask_q),
    .en_o      (en_q),
    .csel_o    (csel_q)
  );

  rsp_data_reg #(.WIDTH(WIDTH)) u_data (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_q),
    .hw_tick_i (hw_tick),
    .sw_tick_i (tick_i),
    .sw_wr_i   (data_wr),
    .sw_data_i (wr_data_i),
    .hw_data_i (sel_vec),
    .data_o    (data_q)
  );

  // bypassed bits form a pure combinational path
  assign route_o = (mask_q & data_q) | (~mask_q & sel_vec);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= route_o;
  end
endmodule

// File: rtl/sig_route_port_chk.sv
module sig_route_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_q,
  input logic             hw_tick,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic [WIDTH-1:0] wr_data_i,
  input logic [WIDTH-1:0] data_q,
  input logic [WIDTH-1:0] mask_q,
  input logic [WIDTH-1:0] sel_vec,
  input logic [WIDTH-1:0] route_o,
  input logic [WIDTH-1:0] rd_data_o
);
  logic sw_wr;
  assign sw_wr = wr_en_i && (wr_addr_i == 2'd0) && tick_i;

  a_r1_masked_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((route_o ^ data_q) & mask_q) == '0);

  a_r2_bypass_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((route_o ^ sel_vec) & ~mask_q) == '0);

  a_r4_sw_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && sw_wr) |=> (data_q == $past(wr_data_i)));

  a_r4_sw_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !sw_wr) |=> $stable(data_q));

  a_r5_hw_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && hw_tick) |=> (data_q == $past(sel_vec)));

  a_r6_lockout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !hw_tick) |=> $stable(data_q));

  a_r7_read_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (rd_data_o == $past(route_o)));
endmodule

bind sig_route_port sig_route_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_q      (en_q),
  .hw_tick   (hw_tick),
  .tick_i    (tick_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .data_q    (data_q),
  .mask_q    (mask_q),
  .sel_vec   (sel_vec),
  .route_o   (route_o),
  .rd_data_o (rd_data_o)
);

// File: tb/sim_sig_route_port.sv
module sim_sig_route_port;
  localparam int W  = 8;
  localparam int NS = 4;
  localparam int SW = 2;
  localparam int NC = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            tick_i = 1'b0;
  logic [NC-1:0]   clk_stb_i = '0;
  logic [W*NS-1:0] src_i = '0;
  logic [W*SW-1:0] src_sel_i = '0;
  logic            wr_en_i = 1'b0;
  logic [1:0]      wr_addr_i = '0;
  logic [W-1:0]    wr_data_i = '0;
  logic [W-1:0]    rd_data_o;
  logic [W-1:0]    route_o;

  int n_chk = 0;
  int n_err = 0;

  logic [W-1:0] m_data = '0;
  logic [W-1:0] m_mask = '0;
  logic         m_en   = 1'b0;
  logic [1:0]   m_csel = '0;
  logic [W-1:0] m_rd   = '0;

  always #5 clk_i = ~clk_i;

  sig_route_port #(.WIDTH(W), .NSRC(NS), .NCLK(NC)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .clk_stb_i(clk_stb_i),
    .src_i(src_i), .src_sel_i(src_sel_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .route_o(route_o)
  );

  function automatic logic [W-1:0] f_sel(logic [W*NS-1:0] s, logic [W*SW-1:0] q);
    logic [W-1:0] v;
    for (int b = 0; b < W; b++) v[b] = s[b*NS + int'(q[b*SW +: SW])];
    return v;
  endfunction

  function automatic logic [W-1:0] f_route(logic [W-1:0] sel);
    return (m_mask & m_data) | (~m_mask & sel);
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle, check against model, then advance model past the edge
  task automatic step(logic we, logic [1:0] addr, logic [W-1:0] wd, logic tk,
                      logic [NC-1:0] stb, logic [W*NS-1:0] src, logic [W*SW-1:0] qs);
    logic [W-1:0] sel;
    logic [W-1:0] er;
    @(negedge clk_i);
    wr_en_i = we; wr_addr_i = addr; wr_data_i = wd; tick_i = tk;
    clk_stb_i = stb; src_i = src; src_sel_i = qs;
    #1;
    sel = f_sel(src, qs);
    er  = f_route(sel);
    chk("R1 masked bits", route_o & m_mask, er & m_mask);
    chk("R2 R3 bypassed bits", route_o & ~m_mask, er & ~m_mask);
    chk("R7 readback", rd_data_o, m_rd);
    m_rd = er;
    if (m_en) begin
      if (stb[m_csel]) m_data = sel;
    end else if (we && addr == 2'd0 && tk) begin
      m_data = wd;
    end
    if (we && addr == 2'd1) m_mask = wd;
    if (we && addr == 2'd2) begin
      m_en = wd[0]; m_csel = wd[2:1];
    end
  endtask

  task automatic idle(logic [W*NS-1:0] src, logic [W*SW-1:0] qs);
    step(1'b0, 2'd0, '0, 1'b0, '0, src, qs);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [W*NS-1:0] s_pat;
    logic [W*NS-1:0] r_src;
    logic [W*SW-1:0] r_q;
    void'($urandom(32'd7091));
    // R9: state during and after reset
    #23;
    chk("R9 route in reset", route_o, 8'h00);
    chk("R9 read in reset", rd_data_o, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;
    #1 chk("R9 read after reset", rd_data_o, 8'h00);

    step(1'b1, 2'd1, 8'hFF, 1'b0, '0, '0, '0);            // R10 mask without tick
    step(1'b1, 2'd0, 8'hA5, 1'b0, '0, '0, '0);            // no tick
    idle('0, '0);
    chk("R4 write without tick ignored", route_o, 8'h00);
    step(1'b1, 2'd0, 8'hA5, 1'b1, '0, '0, '0);
    idle('0, '0);
    chk("R4 write with tick", route_o, 8'hA5);
    chk("R7 read right after write", rd_data_o, 8'h00);
    step(1'b1, 2'd3, 8'h5A, 1'b1, '0, '0, '0);            // R10 address 3
    idle('0, '0);
    chk("R10 address 3 ignored", route_o, 8'hA5);
    step(1'b1, 2'd2, 8'h05, 1'b0, '0, '0, '0);            // enable, strobe 2
    step(1'b1, 2'd0, 8'h3C, 1'b1, '0, '0, '0);
    idle('0, '0);
    chk("R6 write locked out", route_o, 8'hA5);
    chk("R8 preset kept after enable", route_o, 8'hA5);
    s_pat = {(W*NS){1'b1}};
    step(1'b0, 2'd0, '0, 1'b1, 4'b1011, s_pat, '0);
    idle('0, '0);
    chk("R5 other strobes ignored", route_o, 8'hA5);
    step(1'b0, 2'd0, '0, 1'b0, 4'b0100, s_pat, '0);
    idle('0, '0);
    chk("R5 selected strobe loads", route_o, 8'hFF);
    // R3: bit b picks source (b mod 4); only that source is high
    step(1'b1, 2'd1, 8'h00, 1'b0, '0, '0, '0);
    for (int b = 0; b < W; b++) begin
      s_pat = '0;
      s_pat[b*NS + (b % NS)] = 1'b1;
      r_q = '0;
      for (int k = 0; k < W; k++) r_q[k*SW +: SW] = 2'(k % NS);
      idle(s_pat, r_q);
      chk("R3 per-bit source", route_o, 8'(1 << b));
    end

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      r_src = {$urandom, $urandom};
      r_q   = 16'($urandom);
      if (r[3:0] == 4'd0)
        step(1'b1, 2'd2, 8'($urandom), r[4], 4'($urandom), r_src, r_q);
      else
        step(r[5], 2'(r[7:6]), 8'($urandom), r[8], 4'($urandom), r_src, r_q);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule